// File: doc/BRIEF.md
# Lane Byte Shuffle Unit

This unit rearranges the bytes of a vector of up to 64 bytes. Each result byte has its own control byte. The control byte either forces the result byte to zero or picks one byte of the data vector by index. The index always stays inside the 16-byte lane that holds the result byte. The operation width is 8, 16, 32 or 64 bytes. A per-byte write mask can be switched on. When it is on, each unselected byte either keeps its previous destination value or becomes zero. Bytes above the active width are zeroed or kept according to a policy input.

For an in-place operation the caller drives the current destination on both `data_vec` and `old_dest`. Every lookup reads that input vector as it was presented, so no lookup ever sees a byte that the same operation has already rewritten. The result is registered once. `out_valid` follows `in_valid` by one cycle, and there is no backpressure.

Top module: `lane_byte_shuffle`

## Requirements
- R1: When bit 7 of a control byte is 1 and that byte is written, the result byte is 0x00, whatever the other control bits hold.
- R2: In the 16-, 32- and 64-byte widths, result byte j takes data byte (j with its low 4 bits cleared) + (control bits 3:0). A lookup therefore never leaves the 16-byte lane of byte j.
- R3: In the 8-byte width (width_sel 2'b00), the index is control bits 2:0 and selects one of data bytes 0 to 7. Control bit 3 has no effect. Example: control 64'hFF80070000000107 applied to data 64'h040107030202FF01 gives 64'h000004010101FF04.
- R4: With mask_en=1 and zero_mode=0, an active byte whose wr_mask bit is 0 keeps its old_dest value. This holds even when its control byte has bit 7 set.
- R5: With mask_en=1 and zero_mode=1, an active byte whose wr_mask bit is 0 becomes 0x00.
- R6: With mask_en=0, wr_mask is ignored and every active byte receives its shuffle result.
- R7: With mask_en=1, every byte at or above the active width (8 << width_sel bytes) is 0x00, whatever keep_upper holds.
- R8: With mask_en=0, bytes at or above the active width keep old_dest when keep_upper=1 and are 0x00 when keep_upper=0.
- R9: out_vec takes the result one cycle after a cycle with in_valid=1. out_valid equals in_valid of the previous cycle. out_vec holds its value while in_valid stays low.
- R10: While rst_n is low, out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| in_valid | input | 1 | Operands valid this cycle |
| width_sel | input | 2 | Width: 00 = 8 B, 01 = 16 B, 10 = 32 B, 11 = 64 B |
| mask_en | input | 1 | Enables per-byte write masking |
| zero_mode | input | 1 | With masking on, unselected bytes are zeroed (1) or merged (0) |
| keep_upper | input | 1 | With masking off, bytes above the width keep old_dest (1) or are zeroed (0) |
| wr_mask | input | 64 | Per-byte write mask, bit j for byte j |
| ctrl_vec | input | 512 | Control bytes, byte j at bits 8j+7:8j |
| data_vec | input | 512 | Lookup table bytes |
| old_dest | input | 512 | Previous destination value |
| out_valid | output | 1 | out_vec holds a new result |
| out_vec | output | 512 | Registered result |

## Verification
The bit-7 zeroing rule and the write mask can act on the same byte in the same cycle. The bench provokes this by issuing an all-zero mask in merge mode together with control bytes that all have bit 7 set, so every byte carries a conflict. The mask must win, and the expected result is the untouched old destination. The bench also issues random operations in which both fields vary freely. It judges each result against a per-byte reference model, with pushes and pops running back to back.

// File: rtl/shuf_pkg.sv
package shuf_pkg;
  typedef enum logic [1:0] {
    WID_8B  = 2'b00,
    WID_16B = 2'b01,
    WID_32B = 2'b10,
    WID_64B = 2'b11
  } width_e;

  localparam int MIN_BYTES = 8;
endpackage

// File: rtl/shuf_lane_pick.sv
// One result byte: picks a byte from its own lane, or zero on control bit 7.
module shuf_lane_pick #(
  parameter int LANE_BYTES = 16,
  localparam int IDX_W = $clog2(LANE_BYTES)
) (
  input  logic [LANE_BYTES*8-1:0] lane_data,
  input  logic [7:0]              ctrl_b,
  input  logic                    narrow,
  output logic [7:0]              pick_b
);
  logic [IDX_W-1:0] idx;
  logic             unused_ctrl;

  assign unused_ctrl = ^ctrl_b[6:IDX_W];

  always_comb begin
    idx = ctrl_b[IDX_W-1:0];
    if (narrow) idx[IDX_W-1] = 1'b0;
    if (ctrl_b[7]) pick_b = 8'h00;
    else           pick_b = lane_data[idx*8 +: 8];
  end
endmodule

// File: rtl/shuf_byte_fin.sv
// Applies the width, mask and upper-byte policies to one picked byte.
module shuf_byte_fin (
  input  logic [7:0] pick_b,
  input  logic [7:0] old_b,
  input  logic       active,
  input  logic       mask_en,
  input  logic       mbit,
  input  logic       zero_mode,
  input  logic       keep_upper,
  output logic [7:0] res_b
);
  always_comb begin
    if (!active)              res_b = (!mask_en && keep_upper) ? old_b : 8'h00;
    else if (mask_en && !mbit) res_b = zero_mode ? 8'h00 : old_b;
    else                       res_b = pick_b;
  end
endmodule

// File: rtl/lane_byte_shuffle.sv
module lane_byte_shuffle
  import shuf_pkg::*;
#(
  parameter int MAX_BYTES  = 64,
  parameter int LANE_BYTES = 16,
  localparam int VEC_W = MAX_BYTES * 8,
  localparam int CNT_W = $clog2(MAX_BYTES) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       width_sel,
  input  logic             mask_en,
  input  logic             zero_mode,
  input  logic             keep_upper,
  input  logic [MAX_BYTES-1:0] wr_mask,
  input  logic [VEC_W-1:0] ctrl_vec,
  input  logic [VEC_W-1:0] data_vec,
  input  logic [VEC_W-1:0] old_dest,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_vec
);
  width_e           wsel;
  logic [CNT_W-1:0] act_bytes;
  logic             narrow;
  logic [VEC_W-1:0] res_nxt;
  logic             vld_nxt;
  logic [VEC_W-1:0] vec_q;
  logic             vld_q;

  assign wsel      = width_e'(width_sel);
  assign act_bytes = CNT_W'(MIN_BYTES) << width_sel;
  assign narrow    = (wsel == WID_8B);

  for (genvar j = 0; j < MAX_BYTES; j++) begin : g_byte
    localparam int LANE = j / LANE_BYTES;
    localparam logic [CNT_W-1:0] JB = CNT_W'(j);
    logic [7:0] pick_b;

    shuf_lane_pick #(.LANE_BYTES(LANE_BYTES)) pick_i (
      .lane_data (data_vec[LANE*LANE_BYTES*8 +: LANE_BYTES*8]),
      .ctrl_b    (ctrl_vec[j*8 +: 8]),
      .narrow    (narrow),
      .pick_b    (pick_b)
    );

    shuf_byte_fin fin_i (
      .pick_b     (pick_b),
      .old_b      (old_dest[j*8 +: 8]),
      .active     (JB < act_bytes),
      .mask_en    (mask_en),
      .mbit       (wr_mask[j]),
      .zero_mode  (zero_mode),
      .keep_upper (keep_upper),
      .res_b      (res_nxt[j*8 +: 8])
    );
  end

  // next-state
  assign vld_nxt = in_valid;

  // registers: valid is reset, data is load-enabled only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_nxt;
  end

  always_ff @(posedge clk) begin
    if (in_valid) vec_q <= res_nxt;
  end

  assign out_valid = vld_q;
  assign out_vec   = vec_q;

  assert_valid_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_valid == $past(in_valid)));

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !in_valid) |=> $stable(out_vec));

  assert_bit7_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mask_en && ctrl_vec[7]) |=> (out_vec[7:0] == 8'h00));

  assert_merge_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mask_en && !zero_mode && !wr_mask[0]) |=> (out_vec[7:0] == $past(old_dest[7:0])));

  assert_zero_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mask_en && zero_mode && (wr_mask == '0)) |=> (out_vec == '0));

  assert_upper_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mask_en && (width_sel == 2'b00)) |=> (out_vec[VEC_W-1:64] == '0));

  assert_upper_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mask_en && keep_upper && (width_sel == 2'b01))
      |=> (out_vec[VEC_W-1:128] == $past(old_dest[VEC_W-1:128])));

  always @(negedge clk) begin
    if (!rst_n) assert_reset_low_R10: assert (out_valid == 1'b0);
  end
endmodule

// File: tb/lane_byte_shuffle_tb_top.sv
`timescale 1ns/1ps
module lane_byte_shuffle_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [1:0]   width_sel;
  logic         mask_en, zero_mode, keep_upper;
  logic [63:0]  wr_mask;
  logic [511:0] ctrl_vec, data_vec, old_dest;
  logic         out_valid;
  logic [511:0] out_vec;

  int total = 0;
  int bad   = 0;
  logic [511:0] exp_q[$];
  string        tag_q[$];
  logic [511:0] last_vec;
  logic         have_last = 1'b0;
  bit           done = 1'b0;

  always #5 clk = ~clk;

  lane_byte_shuffle dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .width_sel(width_sel),
    .mask_en(mask_en), .zero_mode(zero_mode), .keep_upper(keep_upper),
    .wr_mask(wr_mask), .ctrl_vec(ctrl_vec), .data_vec(data_vec),
    .old_dest(old_dest), .out_valid(out_valid), .out_vec(out_vec)
  );

  function automatic logic [511:0] model(input logic [511:0] c, input logic [511:0] d,
      input logic [511:0] o, input logic [63:0] m, input logic [1:0] w,
      input logic men, input logic zm, input logic ku);
    logic [511:0] r;
    int nb;
    nb = 8 * (1 << w);
    r = '0;
    for (int j = 0; j < 64; j++) begin
      logic [7:0] cb;
      int src;
      cb = c[j*8 +: 8];
      if (j >= nb) begin
        r[j*8 +: 8] = (!men && ku) ? o[j*8 +: 8] : 8'h00;
      end else if (men && !m[j]) begin
        r[j*8 +: 8] = zm ? 8'h00 : o[j*8 +: 8];
      end else if (cb[7]) begin
        r[j*8 +: 8] = 8'h00;
      end else begin
        if (w == 2'b00) src = int'(cb[2:0]);
        else            src = (j / 16) * 16 + int'(cb[3:0]);
        r[j*8 +: 8] = d[src*8 +: 8];
      end
    end
    return r;
  endfunction

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int k = 0; k < 16; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [511:0] c, input logic [511:0] d, input logic [511:0] o,
      input logic [63:0] m, input logic [1:0] w, input logic men, input logic zm,
      input logic ku, input string tag);
    @(negedge clk);
    in_valid = 1'b1; ctrl_vec = c; data_vec = d; old_dest = o; wr_mask = m;
    width_sel = w; mask_en = men; zero_mode = zm; keep_upper = ku;
    exp_q.push_back(model(c, d, o, m, w, men, zm, ku));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      ctrl_vec = rnd512(); data_vec = rnd512(); old_dest = rnd512();
    end
  endtask

  // monitor: pops expected items as results appear, checks hold while idle
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected out_valid", out_vec, '0);
        end else begin
          logic [511:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_vec === e, t, out_vec, e);
        end
      end else if (have_last) begin
        check(out_vec === last_vec, "R9 hold while idle", out_vec, last_vec);
      end
      if (out_valid) have_last = 1'b1;
      last_vec = out_vec;
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired R9 actual=%0d expected=0", exp_q.size());
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [511:0] c, d, o;
    rst_n = 1'b0; in_valid = 1'b0; width_sel = 2'b11; mask_en = 1'b0;
    zero_mode = 1'b0; keep_upper = 1'b0; wr_mask = '0;
    ctrl_vec = '0; data_vec = '0; old_dest = '0;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R10 out_valid in reset", {511'd0, out_valid}, '0);
    @(posedge clk); rst_n <= 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R10 out_valid after reset", {511'd0, out_valid}, '0);

    // R3 worked 8-byte example with a literal expectation
    c = rnd512(); d = rnd512(); o = rnd512();
    c[63:0] = 64'hFF80070000000107; d[63:0] = 64'h040107030202FF01;
    drive(c, d, o, '1, 2'b00, 1'b0, 1'b0, 1'b0, "R3 worked example");
    @(negedge clk); in_valid = 1'b0;
    #1 check(out_vec[63:0] === 64'h000004010101FF04 && out_vec[511:64] === '0,
             "R3 literal result", out_vec, {448'd0, 64'h000004010101FF04});
    idle(1);

    // R3 bit 3 ignored in 8-byte width
    c = rnd512();
    for (int j = 0; j < 8; j++) c[j*8 +: 8] = 8'h08 | 8'(j);
    drive(c, rnd512(), rnd512(), '1, 2'b00, 1'b0, 1'b0, 1'b1, "R3 index bit3 ignored");
    // R1 all bit 7 set
    c = rnd512();
    for (int j = 0; j < 64; j++) c[j*8+7] = 1'b1;
    drive(c, rnd512(), rnd512(), '1, 2'b11, 1'b0, 1'b0, 1'b0, "R1 all bit7 set");
    // R2 index 15 everywhere
    c = '0;
    for (int j = 0; j < 64; j++) c[j*8 +: 8] = 8'h0F;
    drive(c, rnd512(), rnd512(), '1, 2'b11, 1'b0, 1'b0, 1'b0, "R2 index 15 per lane");
    drive(c, rnd512(), rnd512(), '1, 2'b10, 1'b0, 1'b0, 1'b0, "R2 index 15 32B");
    // R4 merge with all-zero mask and bit-7 controls (conflict)
    c = rnd512();
    for (int j = 0; j < 64; j++) c[j*8+7] = 1'b1;
    drive(c, rnd512(), rnd512(), '0, 2'b11, 1'b1, 1'b0, 1'b0, "R4 zero mask merge");
    drive(rnd512(), rnd512(), rnd512(), '0, 2'b11, 1'b1, 1'b1, 1'b0, "R5 zero mask zeroing");
    drive(rnd512(), rnd512(), rnd512(), '0, 2'b10, 1'b0, 1'b1, 1'b0, "R6 mask ignored");
    idle(2);
    drive(rnd512(), rnd512(), rnd512(), {$urandom, $urandom}, 2'b01, 1'b1, 1'b0, 1'b1, "R7 masked 16B upper");
    drive(rnd512(), rnd512(), rnd512(), {$urandom, $urandom}, 2'b00, 1'b1, 1'b1, 1'b1, "R7 masked 8B upper");
    drive(rnd512(), rnd512(), rnd512(), '1, 2'b01, 1'b0, 1'b0, 1'b1, "R8 keep upper");
    drive(rnd512(), rnd512(), rnd512(), '1, 2'b01, 1'b0, 1'b0, 1'b0, "R8 clear upper");
    // in-place: data and old destination are the same vector
    o = rnd512();
    drive(rnd512() & {64{8'h8F}}, o, o, {$urandom, $urandom}, 2'b11, 1'b1, 1'b0, 1'b0, "R2 R4 in-place");
    idle(3);

    for (int n = 0; n < 300; n++) begin
      drive(rnd512() & {64{8'h8F}} | (($urandom % 4 == 0) ? rnd512() : '0), rnd512(), rnd512(),
            {$urandom, $urandom}, 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            "R1 R2 R3 R4 R5 R7 R8 random");
      if ($urandom % 5 == 0) idle(1 + $urandom % 3);
    end
    idle(3);
    done = 1'b1;
    check(exp_q.size() == 0, "R9 all results returned", 512'(exp_q.size()), '0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule